// File: doc/BRIEF.md
# ISA Bus Cycle Bridge

The bridge turns single requests from a host memory-mapped local bus into ISA-style memory or I/O cycles. Two 4 MB host windows are decoded: one produces memory cycles, the other I/O cycles. In both, the low 22 host address bits pass straight through. The top two ISA address bits come from a small configuration register that holds one pair for each space. Both spaces therefore cover a full 24-bit address, and I/O space is not cut down to 64 KB.

Each cycle is timed in host clocks and runs through four parts:
- an address and data setup phase;
- a command strobe that the addressed device can stretch by pulling its ready line low;
- a hold phase;
- a one-clock acknowledge to the host.

The device's 16-bit select line for the addressed space decides the cycle's width. It is sampled shortly before the strobe starts. The bridge also drives an enable and a direction for an external data buffer, and it asserts the ISA reset line while it is itself in reset. It passes the device interrupt lines through a two-stage synchroniser.

The host holds a request until it sees the acknowledge pulse. An access goes out on the ISA side only when the enable bit is set and the address falls in one of the two windows. Any other access completes on the next clock and returns zero.

Top module: `isa_bridge`

## Requirements
- R1: An accepted address in 0x1B800000..0x1BBFFFFF produces a memory cycle (MEMR# low for reads, MEMW# low for writes). An accepted address in 0x1BC00000..0x1BFFFFFF produces an I/O cycle (IOR#/IOW# low). The ISA address is {SA23:22, host[21:0]}, where SA23:22 is configuration bits 1:0 for memory and 5:4 for I/O. The address stays stable while the buffer enable is low.
- R2: The configuration register resets to 0x00. A write stores bits 7, 5, 4, 1 and 0, and bits 6, 3 and 2 read back as 0. Bit 7 = 1 enables the ISA side.
- R3: When bit 7 is 0, or the address is outside both windows, an accepted request is acknowledged in the first cycle after acceptance. No strobe and no buffer enable go active, and h_rdata is 0.
- R4: The buffer enable goes low in the first cycle after acceptance. The command strobe starts 6 cycles later. If ready is high when it is sampled, the strobe lasts exactly 8 cycles.
- R5: Ready is sampled at the end of the 4th strobe cycle and at the end of every later stretched cycle. If it is sampled low on L consecutive edges, the strobe lasts 8+L cycles, ending 4 cycles after the edge at which ready is first seen high.
- R6: After the strobe, the address and buffer enable stay active for 3 more cycles. h_ack is then high for exactly one cycle.
- R7: The 16-bit select of the addressed space (MEMCS16# for memory, IOCS16# for I/O, active low) is sampled at the end of the 4th setup cycle, 2 clocks before the strobe, and later changes have no effect. h_full = h_wide AND select active. A read that is not full returns zero in h_rdata[15:8].
- R8: For writes, isa_dout carries h_wdata and isa_dout_oe is high from the first setup cycle to the last hold cycle. isa_sbhe_n is low during a cycle whose request had h_wide set.
- R9: Read data is captured from isa_din at the edge that ends the last strobe cycle. It is presented on h_rdata during the acknowledge cycle.
- R10: isa_bufen_n is low exactly during setup, strobe and hold. isa_dir_rd is 1 for reads and 0 for writes during the cycle.
- R11: isa_resetdrv is high while rst_n is low and low otherwise. irq_q follows isa_irq with a delay of two clock edges.
- R12: At most one of the four command strobes is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all ISA timing is counted in it |
| rst_n | input | 1 | Active-low reset |
| h_req | input | 1 | Host request, held until h_ack |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_wide | input | 1 | Host asks for a 16-bit transfer |
| h_addr | input | 32 | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_ack | output | 1 | One-cycle completion pulse |
| h_rdata | output | 16 | Read data, valid with h_ack |
| h_full | output | 1 | Transfer was 16 bits wide, valid with h_ack |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_q | output | 8 | Configuration register contents |
| isa_addr | output | 24 | ISA address |
| isa_sbhe_n | output | 1 | Upper byte valid, active low |
| isa_memr_n | output | 1 | Memory read strobe |
| isa_memw_n | output | 1 | Memory write strobe |
| isa_ior_n | output | 1 | I/O read strobe |
| isa_iow_n | output | 1 | I/O write strobe |
| isa_dout | output | 16 | Write data toward the ISA side |
| isa_dout_oe | output | 1 | Write data drive enable |
| isa_din | input | 16 | Read data from the ISA side |
| isa_bufen_n | output | 1 | External data buffer enable, active low |
| isa_dir_rd | output | 1 | Buffer direction, 1 = toward host |
| isa_resetdrv | output | 1 | ISA reset |
| isa_iochrdy | input | 1 | Device ready, low stretches the strobe |
| isa_memcs16_n | input | 1 | Memory device is 16-bit, active low |
| isa_iocs16_n | input | 1 | I/O device is 16-bit, active low |
| isa_irq | input | 4 | Device interrupt requests |
| irq_q | output | 4 | Synchronised interrupt requests |

## Verification
Two cases are hardest to reach from the ports:
- A stretched strobe in which ready drops exactly on the first sampling edge and rises again several edges later.
- A width select that flips right after its sampling edge.

Both need pin changes aligned to single clocks deep inside a cycle. The bench therefore drives each transaction from a predicted per-cycle schedule. It holds ready low for exactly L chosen edges from the 10th edge after acceptance, and it inverts both select pins from the 5th edge on. It also presents the correct read data only on the edge that ends the strobe and the complement on every other edge. Any early or late sampling then shows up in h_full, h_rdata or the strobe length.

// File: rtl/isa_br_pkg.sv
package isa_br_pkg;
  localparam int ISA_WIN_W = 22;
  localparam int ISA_AW    = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CMD, S_WAIT, S_TAIL, S_HOLD, S_DONE
  } isa_st_e;

  // host address lies in the window starting at base
  function automatic logic win_hit(input logic [31:0] a, input logic [31:0] base);
    return ((a ^ base) >> ISA_WIN_W) == 32'd0;
  endfunction

  // ISA address from selected upper pair and window offset
  function automatic logic [ISA_AW-1:0] isa_map(input logic [1:0] sa,
                                                input logic [ISA_WIN_W-1:0] lo);
    return {sa, lo};
  endfunction

  // read data seen by host for the decided width
  function automatic logic [15:0] narrow(input logic [15:0] d, input logic full);
    return full ? d : {8'h00, d[7:0]};
  endfunction
endpackage

// File: rtl/isa_br_cfg.sv
module isa_br_cfg #(
  parameter logic [7:0] MASK = 8'hB3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       en,
  output logic [1:0] mem_sa,
  output logic [1:0] io_sa
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 8'h00;
    else if (wr) q <= wdata & MASK;
  end

  assign en     = q[7];
  assign mem_sa = q[1:0];
  assign io_sa  = q[5:4];
endmodule

// File: rtl/isa_br_sync.sv
module isa_br_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/isa_br_seq.sv
module isa_br_seq
  import isa_br_pkg::*;
#(
  parameter int          T_SETUP  = 6,
  parameter int          T_CS16   = 2,
  parameter int          T_RDY    = 4,
  parameter int          T_TAIL   = 4,
  parameter int          T_HOLD   = 3,
  parameter logic [31:0] MEM_BASE = 32'h1B80_0000,
  parameter logic [31:0] IO_BASE  = 32'h1BC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_wr,
  input  logic              h_wide,
  input  logic [31:0]       h_addr,
  input  logic [15:0]       h_wdata,
  output logic              h_ack,
  output logic [15:0]       h_rdata,
  output logic              h_full,
  input  logic              en,
  input  logic [1:0]        mem_sa,
  input  logic [1:0]        io_sa,
  output logic [ISA_AW-1:0] isa_addr,
  output logic              sbhe_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic [15:0]       dout,
  output logic              dout_oe,
  input  logic [15:0]       din,
  output logic              bufen_n,
  output logic              dir_rd,
  input  logic              iochrdy,
  input  logic              memcs16_n,
  input  logic              iocs16_n
);
  localparam int CNT_W = $clog2(T_SETUP + T_RDY + T_TAIL + T_HOLD + 1);

  isa_st_e            st;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q, wide_q, io_q, full_q;
  logic [15:0]        wd_q, rd_q;
  logic [ISA_AW-1:0]  addr_q;

  // named internal events
  logic hit_mem, hit_io, go, cs16_pt, setup_end, rdy_pt, tail_end, hold_end;
  logic busy, cmd_on, cs16_now;

  assign hit_mem   = win_hit(h_addr, MEM_BASE);
  assign hit_io    = win_hit(h_addr, IO_BASE);
  assign go        = en & (hit_mem | hit_io);
  assign cs16_pt   = (st == S_SETUP) && (cnt == CNT_W'(T_SETUP - T_CS16 - 1));
  assign setup_end = (st == S_SETUP) && (cnt == CNT_W'(T_SETUP - 1));
  assign rdy_pt    = (st == S_CMD)   && (cnt == CNT_W'(T_RDY - 1));
  assign tail_end  = (st == S_TAIL)  && (cnt == CNT_W'(T_TAIL - 1));
  assign hold_end  = (st == S_HOLD)  && (cnt == CNT_W'(T_HOLD - 1));
  assign cs16_now  = ~(io_q ? iocs16_n : memcs16_n);
  assign busy      = st inside {S_SETUP, S_CMD, S_WAIT, S_TAIL, S_HOLD};
  assign cmd_on    = st inside {S_CMD, S_WAIT, S_TAIL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      io_q   <= 1'b0;
      full_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      addr_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (h_req) begin
          wr_q   <= h_wr;
          wide_q <= h_wide;
          wd_q   <= h_wdata;
          io_q   <= hit_io;
          addr_q <= isa_map(hit_io ? io_sa : mem_sa, h_addr[ISA_WIN_W-1:0]);
          full_q <= 1'b0;
          cnt    <= '0;
          if (go) st <= S_SETUP;
          else begin
            st   <= S_DONE;
            rd_q <= '0;
          end
        end
        S_SETUP: begin
          if (cs16_pt) full_q <= wide_q & cs16_now;
          if (setup_end) begin
            cnt <= '0;
            st  <= S_CMD;
          end else cnt <= cnt + 1'b1;
        end
        S_CMD: begin
          if (rdy_pt) begin
            cnt <= '0;
            st  <= iochrdy ? S_TAIL : S_WAIT;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: if (iochrdy) st <= S_TAIL;
        S_TAIL: begin
          if (tail_end) begin
            cnt <= '0;
            st  <= S_HOLD;
            if (!wr_q) rd_q <= narrow(din, full_q);
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (hold_end) begin
            cnt <= '0;
            st  <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign h_ack    = (st == S_DONE);
  assign h_rdata  = rd_q;
  assign h_full   = full_q;
  assign isa_addr = addr_q;
  assign sbhe_n   = ~(busy & wide_q);
  assign memr_n   = ~(cmd_on & ~io_q & ~wr_q);
  assign memw_n   = ~(cmd_on & ~io_q &  wr_q);
  assign ior_n    = ~(cmd_on &  io_q & ~wr_q);
  assign iow_n    = ~(cmd_on &  io_q &  wr_q);
  assign dout     = wd_q;
  assign dout_oe  = busy & wr_q;
  assign bufen_n  = ~busy;
  assign dir_rd   = ~wr_q;
endmodule

// File: rtl/isa_bridge.sv
module isa_bridge #(
  parameter int          T_SETUP  = 6,
  parameter int          T_CS16   = 2,
  parameter int          T_RDY    = 4,
  parameter int          T_TAIL   = 4,
  parameter int          T_HOLD   = 3,
  parameter int          IRQ_N    = 4,
  parameter logic [31:0] MEM_BASE = 32'h1B80_0000,
  parameter logic [31:0] IO_BASE  = 32'h1BC0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_req,
  input  logic             h_wr,
  input  logic             h_wide,
  input  logic [31:0]      h_addr,
  input  logic [15:0]      h_wdata,
  output logic             h_ack,
  output logic [15:0]      h_rdata,
  output logic             h_full,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_q,
  output logic [23:0]      isa_addr,
  output logic             isa_sbhe_n,
  output logic             isa_memr_n,
  output logic             isa_memw_n,
  output logic             isa_ior_n,
  output logic             isa_iow_n,
  output logic [15:0]      isa_dout,
  output logic             isa_dout_oe,
  input  logic [15:0]      isa_din,
  output logic             isa_bufen_n,
  output logic             isa_dir_rd,
  output logic             isa_resetdrv,
  input  logic             isa_iochrdy,
  input  logic             isa_memcs16_n,
  input  logic             isa_iocs16_n,
  input  logic [IRQ_N-1:0] isa_irq,
  output logic [IRQ_N-1:0] irq_q
);
  logic       en;
  logic [1:0] mem_sa, io_sa;

  assign isa_resetdrv = ~rst_n;

  isa_br_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg_q),
    .en(en), .mem_sa(mem_sa), .io_sa(io_sa)
  );

  isa_br_sync #(.N(IRQ_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(isa_irq), .q(irq_q)
  );

  isa_br_seq #(
    .T_SETUP(T_SETUP), .T_CS16(T_CS16), .T_RDY(T_RDY), .T_TAIL(T_TAIL),
    .T_HOLD(T_HOLD), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_wr(h_wr), .h_wide(h_wide), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ack(h_ack), .h_rdata(h_rdata), .h_full(h_full),
    .en(en), .mem_sa(mem_sa), .io_sa(io_sa),
    .isa_addr(isa_addr), .sbhe_n(isa_sbhe_n),
    .memr_n(isa_memr_n), .memw_n(isa_memw_n), .ior_n(isa_ior_n), .iow_n(isa_iow_n),
    .dout(isa_dout), .dout_oe(isa_dout_oe), .din(isa_din),
    .bufen_n(isa_bufen_n), .dir_rd(isa_dir_rd), .iochrdy(isa_iochrdy),
    .memcs16_n(isa_memcs16_n), .iocs16_n(isa_iocs16_n)
  );
endmodule

// File: rtl/isa_bridge_chk.sv
module isa_bridge_chk #(
  parameter int MIN_CMD = 8,
  parameter int IRQ_N   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             memr_n,
  input logic             memw_n,
  input logic             ior_n,
  input logic             iow_n,
  input logic             bufen_n,
  input logic [23:0]      isa_addr,
  input logic             h_ack,
  input logic             dout_oe,
  input logic             dir_rd,
  input logic [IRQ_N-1:0] isa_irq,
  input logic [IRQ_N-1:0] irq_q
);
  logic       strb;
  logic [7:0] slen;
  logic [1:0] since_rst;

  assign strb = ~(memr_n & memw_n & ior_n & iow_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slen      <= '0;
      since_rst <= '0;
    end else begin
      if (strb) slen <= (slen == 8'hFF) ? slen : slen + 8'd1;
      else      slen <= '0;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~memr_n, ~memw_n, ~ior_n, ~iow_n}));

  p_strobe_in_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !bufen_n);

  p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $past(!bufen_n));

  p_strobe_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb) |-> slen >= 8'(MIN_CMD));

  p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bufen_n && $past(!bufen_n)) |-> $stable(isa_addr));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> !h_ack);

  p_ack_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |-> (!strb && bufen_n));

  p_write_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!bufen_n && !dir_rd));

  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (irq_q == $past(isa_irq, 2)));
endmodule

bind isa_bridge isa_bridge_chk #(.MIN_CMD(T_RDY + T_TAIL), .IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .memr_n(isa_memr_n), .memw_n(isa_memw_n), .ior_n(isa_ior_n), .iow_n(isa_iow_n),
  .bufen_n(isa_bufen_n), .isa_addr(isa_addr), .h_ack(h_ack),
  .dout_oe(isa_dout_oe), .dir_rd(isa_dir_rd), .isa_irq(isa_irq), .irq_q(irq_q)
);

// File: tb/sim_isa_bridge.sv
`timescale 1ns/1ps
module sim_isa_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_wr = 1'b0, h_wide = 1'b0;
  logic [31:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic        h_ack, h_full;
  logic [15:0] h_rdata;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_q;
  logic [23:0] isa_addr;
  logic        isa_sbhe_n, isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n;
  logic [15:0] isa_dout;
  logic        isa_dout_oe, isa_bufen_n, isa_dir_rd, isa_resetdrv;
  logic [15:0] isa_din = '0;
  logic        isa_iochrdy = 1'b1, isa_memcs16_n = 1'b1, isa_iocs16_n = 1'b1;
  logic [3:0]  isa_irq = '0;
  logic [3:0]  irq_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] cfg_sh = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_bridge u0 (.*);

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_sh = v & 8'hB3;
    check(cfg_q == cfg_sh, "R2 cfg readback", cfg_q, cfg_sh);
  endtask

  // drive one host transaction and compare against the predicted schedule
  task automatic run(input bit wr, input bit wide, input logic [31:0] a,
                     input logic [15:0] wd, input logic [15:0] rdv,
                     input bit cs16_act, input int L);
    bit in_mem = (a >= 32'h1B80_0000) && (a <= 32'h1BBF_FFFF);
    bit in_io  = (a >= 32'h1BC0_0000) && (a <= 32'h1BFF_FFFF);
    bit hit    = cfg_sh[7] && (in_mem || in_io);
    bit full   = wide && cs16_act;
    logic [23:0] ea = {in_io ? cfg_sh[5:4] : cfg_sh[1:0], a[21:0]};
    logic [3:0]  sv = in_io ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000);
    logic [15:0] erd = full ? rdv : {8'h00, rdv[7:0]};
    int last = hit ? 18 + L : 1;
    string stag = (L > 0) ? "R5 strobe" : "R4 strobe";
    @(negedge clk);
    h_req = 1'b1; h_wr = wr; h_wide = wide; h_addr = a; h_wdata = wd;
    isa_iochrdy = 1'b1;
    isa_memcs16_n = in_io ? cs16_act : !cs16_act;
    isa_iocs16_n  = in_io ? !cs16_act : cs16_act;
    isa_din = ~rdv;
    for (int j = 1; j <= last; j++) begin
      bit e_busy, e_strb, e_ack;
      logic [3:0] act;
      @(negedge clk);
      e_busy = hit && (j <= 17 + L);
      e_strb = hit && (j >= 7) && (j <= 14 + L);
      e_ack  = (j == last);
      act = {~isa_memr_n, ~isa_memw_n, ~isa_ior_n, ~isa_iow_n};
      check(act == (e_strb ? sv : 4'b0000), hit ? stag : "R3 no strobe", act,
            e_strb ? sv : 4'b0000);
      check(isa_bufen_n == !e_busy, hit ? "R10 bufen" : "R3 no bufen", isa_bufen_n, !e_busy);
      check(h_ack == e_ack, "R6 ack timing", h_ack, e_ack);
      if (e_busy) begin
        check(isa_addr == ea, "R1 address", isa_addr, ea);
        check(isa_dir_rd == !wr, "R10 direction", isa_dir_rd, !wr);
        check(isa_dout_oe == wr, "R8 drive enable", isa_dout_oe, wr);
        check(isa_sbhe_n == !wide, "R8 sbhe", isa_sbhe_n, !wide);
        if (wr) check(isa_dout == wd, "R8 write data", isa_dout, wd);
      end
      if (e_ack) begin
        if (!hit) check(h_rdata == 16'h0, "R3 zero read", h_rdata, 0);
        else begin
          check(h_full == full, "R7 width", h_full, full);
          if (!wr) check(h_rdata == erd, "R9 read data", h_rdata, erd);
        end
        h_req = 1'b0;
      end
      isa_iochrdy = !(hit && (j >= 10) && (j < 10 + L));
      if (j >= 5) begin
        isa_memcs16_n = in_io ? !cs16_act : cs16_act;
        isa_iocs16_n  = in_io ? cs16_act : !cs16_act;
      end
      isa_din = (j == 14 + L) ? rdv : ~rdv;
    end
    @(negedge clk);
    isa_iochrdy = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(isa_resetdrv == 1'b1, "R11 resetdrv in reset", isa_resetdrv, 1);
    check(cfg_q == 8'h00, "R2 reset value", cfg_q, 0);
    check({isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n} == 4'hF, "R12 reset strobes",
          {isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n}, 4'hF);
    check(h_ack == 1'b0, "R6 reset ack", h_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(isa_resetdrv == 1'b0, "R11 resetdrv released", isa_resetdrv, 0);

    // disabled after reset: window access completes at once
    run(1'b0, 1'b1, 32'h1B80_0010, 16'h0, 16'h1234, 1'b1, 0);
    cfg_write(8'hFF);
    run(1'b0, 1'b1, 32'h1B81_2344, 16'h0, 16'hA55A, 1'b1, 0);
    run(1'b1, 1'b1, 32'h1B80_0100, 16'hBEEF, 16'h0, 1'b0, 0);
    cfg_write(8'h91);
    run(1'b1, 1'b0, 32'h1BC0_03F0, 16'h00C3, 16'h0, 1'b0, 3);
    run(1'b0, 1'b1, 32'h1BFF_FFFE, 16'h0, 16'h7E81, 1'b1, 2);
    run(1'b0, 1'b1, 32'h1B9F_0002, 16'h0, 16'hC0DE, 1'b0, 1);
    run(1'b0, 1'b0, 32'h1BC0_0001, 16'h0, 16'h5AA5, 1'b1, 5);
    run(1'b0, 1'b0, 32'h1000_0000, 16'h0, 16'hFFFF, 1'b1, 0);
    cfg_write(8'h4C);
    check(cfg_q == 8'h00, "R2 unused bits", cfg_q, 0);
    cfg_write(8'h31);
    run(1'b1, 1'b1, 32'h1BC0_0000, 16'h1111, 16'h0, 1'b1, 0);

    @(negedge clk);
    isa_irq = 4'b1010;
    @(negedge clk);
    check(irq_q == 4'b0000, "R11 irq one edge", irq_q, 0);
    @(negedge clk);
    check(irq_q == 4'b1010, "R11 irq two edges", irq_q, 4'b1010);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule